// File: doc/BRIEF.md
# Page-Buffered Byte Programmer

This block sits behind a two-wire serial slave front end and turns one write transaction into a single page update of a byte array. The front end first hands it a word address through a one-cycle load strobe. The upper address bits select an 8-byte page and the lower three bits select a starting slot in that page. Each later data strobe places one byte in a page buffer at the current slot and then moves the slot pointer forward. The pointer wraps within the page and never carries into the page number.

When the front end reports Stop after at least one data byte, the block enters a timed programming cycle and raises `busy`. At the end of that cycle, every buffer slot written during the transaction is copied into the 256-byte array in the same clock edge. Bytes of the page that were not written keep their earlier contents. While `busy` is high, the block ignores all strobes, so a front end can answer address polling with a not-acknowledge until `busy` falls. A combinational inspection port shows any array byte without side effects.

The control is a four-state machine:
- `ST_IDLE` waits for an address. On `addr_load` it moves to `ST_ADDRD`.
- `ST_ADDRD` holds a loaded address with no data yet.
  - `addr_load` reloads the address and stays in `ST_ADDRD`.
  - `data_stb` together with `stop` goes to `ST_PROG`.
  - `data_stb` alone goes to `ST_FILL`.
  - `stop` alone goes back to `ST_IDLE`.
- `ST_FILL` is collecting bytes.
  - `addr_load` goes back to `ST_ADDRD` and discards the buffered bytes.
  - `stop` goes to `ST_PROG`.
- `ST_PROG` is programming. When the cycle timer expires, it commits the buffer and returns to `ST_IDLE`.

Top module: `pgw_page_programmer`

## Requirements
- R1: After reset, `busy` is 0, the machine is idle and every array byte reads 0.
- R2: An accepted `addr_load` sets the page to `load_addr[7:3]` and the slot to `load_addr[2:0]`. Each accepted data byte goes to slot {page, slot}. The slot then advances by one while the page bits stay fixed.
- R3: Advancing from slot 7 returns the slot to 0 of the same page.
- R4: With more than 8 data bytes before Stop, the slot rolls over. The committed value of a slot is the last byte written to it.
- R5: Programming starts only on Stop after at least one data byte. All written bytes reach the array together on the clock edge where `busy` falls. The array is unchanged before that edge.
- R6: `busy` rises on the edge that accepts Stop and stays high for exactly PROG_CYCLES clock cycles.
- R7: While `busy` is high, `addr_load`, `data_stb` and `stop` have no effect on the buffer, the array or the machine.
- R8: Only slots written in the transaction are updated. The other bytes of the page keep their values.
- R9: Stop with no data byte after the address starts no programming cycle. `busy` stays 0 and the array is unchanged.
- R10: A data byte strobed in the same cycle as Stop is stored and is included in the commit.
- R11: `addr_load` in the same cycle as `data_stb` or `stop` takes precedence, and the other strobe is ignored. A reload before Stop discards the bytes buffered so far.
- R12: `data_stb` and `stop` while idle (no address loaded) are ignored.
- R13: After a commit, the written-slot flags are clear. A later transaction does not rewrite slots written by an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | One-cycle strobe: word address valid |
| load_addr | input | 8 | Word address (page in [7:3], slot in [2:0]) |
| data_stb | input | 1 | One-cycle strobe: data byte valid |
| data_in | input | 8 | Data byte |
| stop | input | 1 | One-cycle strobe: Stop seen on the bus |
| peek_addr | input | 8 | Array inspection address |
| busy | output | 1 | Programming cycle in progress |
| peek_data | output | 8 | Array byte at `peek_addr` (combinational) |

## Verification
Three pairs of events can land in one cycle:
- A final data byte and Stop in the same cycle.
- An address load together with a data byte.
- An address load together with Stop.

The bench drives each pair on a single clock edge:
- A data byte with Stop, both from the address-only state and from the collecting state. The check is that the committed page contains that byte and that `busy` lasts the full cycle.
- An address load with a data byte, followed by Stop. The bench judges this by whether a programming cycle starts at all, and by the array bytes at the reloaded slot.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDRD,
        ST_FILL,
        ST_PROG
    } pgw_state_t;

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [ADDR_W-1:0]               load_addr,
    input  logic                            wr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            clr,
    output logic [ADDR_W-OFS_W-1:0]         page_o,
    output logic [OFS_W-1:0]                ofs_o,
    output logic [(1<<OFS_W)*DATA_W-1:0]    slot_data_o,
    output logic [(1<<OFS_W)-1:0]           mask_o
);

    localparam int SLOTS  = 1 << OFS_W;
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [SLOTS-1:0]  mask_q;
    logic [DATA_W-1:0] slot_q [SLOTS];

    // pointer and written-slot flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            page_q <= load_addr[ADDR_W-1:OFS_W];
            ofs_q  <= load_addr[OFS_W-1:0];
            mask_q <= '0;
        end else if (wr) begin
            ofs_q         <= ofs_q + OFS_W'(1);
            mask_q[ofs_q] <= 1'b1;
        end else if (clr) begin
            mask_q <= '0;
        end
    end

    // one storage register per slot
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[s] <= '0;
                end else if (wr && !load && (ofs_q == OFS_W'(s))) begin
                    slot_q[s] <= wr_data;
                end
            end
            assign slot_data_o[s*DATA_W +: DATA_W] = slot_q[s];
        end
    endgenerate

    assign page_o = page_q;
    assign ofs_o  = ofs_q;
    assign mask_o = mask_q;

    // R2
    ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !load) |=> (ofs_q == $past(ofs_q) + OFS_W'(1)) && $stable(page_q));

    // R3
    ofs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !load && (ofs_q == '1)) |=> (ofs_q == '0) && $stable(page_q));

endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(CYCLES - 1)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = run && (cnt_q == CW'(CYCLES - 1));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(CYCLES));

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit,
    input  logic [ADDR_W-OFS_W-1:0]         page,
    input  logic [(1<<OFS_W)*DATA_W-1:0]    slot_data,
    input  logic [(1<<OFS_W)-1:0]           mask,
    input  logic [ADDR_W-1:0]               peek_addr,
    output logic [DATA_W-1:0]               peek_data
);

    localparam int SLOTS = 1 << OFS_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (mask[s]) begin
                    mem_q[{page, OFS_W'(s)}] <= slot_data[s*DATA_W +: DATA_W];
                end
            end
        end
    end

    assign peek_data = mem_q[peek_addr];

    // R5
    array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit ##1 $stable(peek_addr) |-> $stable(peek_data));

endmodule

// File: rtl/pgw_page_programmer.sv
module pgw_page_programmer #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int OFS_W       = 3,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              data_stb,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic              busy,
    output logic [DATA_W-1:0] peek_data
);

    import pgw_pkg::*;

    localparam int SLOTS  = 1 << OFS_W;
    localparam int PAGE_W = ADDR_W - OFS_W;

    pgw_state_t state_q, state_d;

    logic                    buf_load, buf_wr, tmr_run, tmr_done, commit;
    logic [PAGE_W-1:0]       page;
    logic [OFS_W-1:0]        ofs;
    logic [SLOTS*DATA_W-1:0] slot_data;
    logic [SLOTS-1:0]        mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) state_d = ST_ADDRD;
            end
            ST_ADDRD: begin
                if (addr_load)             state_d = ST_ADDRD;
                else if (data_stb && stop) state_d = ST_PROG;
                else if (data_stb)         state_d = ST_FILL;
                else if (stop)             state_d = ST_IDLE;
            end
            ST_FILL: begin
                if (addr_load)  state_d = ST_ADDRD;
                else if (stop)  state_d = ST_PROG;
            end
            ST_PROG: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        buf_load = 1'b0;
        buf_wr   = 1'b0;
        tmr_run  = 1'b0;
        commit   = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                buf_load = addr_load;
            end
            ST_ADDRD, ST_FILL: begin
                buf_load = addr_load;
                buf_wr   = data_stb && !addr_load;
            end
            ST_PROG: begin
                tmr_run = 1'b1;
                busy    = 1'b1;
                commit  = tmr_done;
            end
            default: ;
        endcase
    end

    pgw_page_buf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (buf_load),
        .load_addr   (load_addr),
        .wr          (buf_wr),
        .wr_data     (data_in),
        .clr         (commit),
        .page_o      (page),
        .ofs_o       (ofs),
        .slot_data_o (slot_data),
        .mask_o      (mask)
    );

    pgw_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    pgw_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page      (page),
        .slot_data (slot_data),
        .mask      (mask),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    // R6
    prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop) && ($past(mask) != '0 || $past(data_stb)));

    // R7
    buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> busy && $stable(mask) && $stable(page) && $stable(ofs));

    // R9
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDRD && stop && !data_stb && !addr_load) |=> !busy);

    // R13
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mask == '0));

endmodule

// File: tb/sim_pgw_page_programmer.sv
module sim_pgw_page_programmer;

    localparam int NCYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [7:0] load_addr = '0;
    logic       data_stb = 1'b0;
    logic [7:0] data_in = '0;
    logic       stop = 1'b0;
    logic [7:0] peek_addr = '0;
    logic       busy;
    logic [7:0] peek_data;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pgw_page_programmer #(
        .ADDR_W      (8),
        .DATA_W      (8),
        .OFS_W       (3),
        .PROG_CYCLES (NCYC)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .load_addr (load_addr),
        .data_stb  (data_stb),
        .data_in   (data_in),
        .stop      (stop),
        .peek_addr (peek_addr),
        .busy      (busy),
        .peek_data (peek_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output int v);
        peek_addr = a;
        #1;
        v = peek_data;
    endtask

    task automatic chk_mem(input string tag, input logic [7:0] a, input int exp);
        int v;
        peek(a, v);
        chk(tag, v, exp);
    endtask

    task automatic do_load(input logic [7:0] a);
        load_addr = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        data_in = d; data_stb = 1'b1;
        @(negedge clk);
        data_stb = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", busy, 0);
        chk_mem("R1 array byte 0x00", 8'h00, 0);
        chk_mem("R1 array byte 0xFF", 8'hFF, 0);
    endtask

    task automatic t_single();
        int n;
        do_load(8'h10);
        do_byte(8'hA5);
        do_stop();
        chk("R6 busy right after stop", busy, 1);
        wait_idle(n);
        chk("R6 busy length", n, NCYC);
        chk_mem("R5 committed byte", 8'h10, 8'hA5);
        chk_mem("R8 neighbour untouched", 8'h11, 0);
    endtask

    task automatic t_wrap();
        int n;
        do_load(8'h2D);
        do_byte(8'h01); do_byte(8'h02); do_byte(8'h03); do_byte(8'h04);
        do_stop();
        wait_idle(n);
        chk_mem("R2 slot 5", 8'h2D, 1);
        chk_mem("R2 slot 7", 8'h2F, 3);
        chk_mem("R3 wrapped to slot 0", 8'h28, 4);
        chk_mem("R3 next page untouched", 8'h30, 0);
        chk_mem("R8 slot 1 untouched", 8'h29, 0);
    endtask

    task automatic t_rollover();
        int n;
        do_load(8'h40);
        for (int i = 0; i < 10; i++) do_byte(8'h50 + 8'(i));
        do_stop();
        wait_idle(n);
        chk_mem("R4 slot 0 overwritten", 8'h40, 8'h58);
        chk_mem("R4 slot 1 overwritten", 8'h41, 8'h59);
        chk_mem("R4 slot 7 kept", 8'h47, 8'h57);
        chk_mem("R4 next page untouched", 8'h48, 0);
    endtask

    task automatic t_busy_ignore();
        int n;
        do_load(8'h60);
        do_byte(8'h11);
        do_stop();
        @(negedge clk);
        chk_mem("R5 array unchanged mid-cycle", 8'h60, 0);
        do_load(8'h70);
        do_byte(8'h22);
        do_stop();
        chk("R7 still busy", busy, 1);
        wait_idle(n);
        chk("R7 busy length unaffected", n, NCYC - 4);
        chk_mem("R5 byte landed", 8'h60, 8'h11);
        chk_mem("R7 ignored write", 8'h70, 0);
        @(negedge clk); @(negedge clk);
        chk("R7 ignored stop", busy, 0);
    endtask

    task automatic t_empty_stop();
        do_load(8'h80);
        do_stop();
        chk("R9 no busy", busy, 0);
        @(negedge clk);
        chk("R9 no busy later", busy, 0);
        chk_mem("R9 array unchanged", 8'h80, 0);
    endtask

    task automatic t_same_cycle();
        int n;
        do_load(8'h90);
        do_byte(8'h33);
        data_in = 8'h44; data_stb = 1'b1; stop = 1'b1;
        @(negedge clk);
        data_stb = 1'b0; stop = 1'b0;
        chk("R10 busy after byte+stop", busy, 1);
        wait_idle(n);
        chk("R10 busy length", n, NCYC);
        chk_mem("R10 first byte", 8'h90, 8'h33);
        chk_mem("R10 same-cycle byte", 8'h91, 8'h44);
        do_load(8'h98);
        data_in = 8'h55; data_stb = 1'b1; stop = 1'b1;
        @(negedge clk);
        data_stb = 1'b0; stop = 1'b0;
        chk("R10 busy from address state", busy, 1);
        wait_idle(n);
        chk_mem("R10 only byte committed", 8'h98, 8'h55);
    endtask

    task automatic t_reload();
        int n;
        do_load(8'hA0);
        do_byte(8'h66);
        do_load(8'hB0);
        do_byte(8'h77);
        do_stop();
        wait_idle(n);
        chk_mem("R11 discarded byte", 8'hA0, 0);
        chk_mem("R11 reloaded byte", 8'hB0, 8'h77);
        load_addr = 8'hC0; addr_load = 1'b1; data_in = 8'h88; data_stb = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; data_stb = 1'b0;
        do_stop();
        chk("R11 data ignored under load, no program", busy, 0);
        chk_mem("R11 array unchanged", 8'hC0, 0);
        do_load(8'hC8);
        load_addr = 8'hC8; addr_load = 1'b1; stop = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; stop = 1'b0;
        do_byte(8'h12);
        do_stop();
        chk("R11 stop under load ignored", busy, 1);
        wait_idle(n);
        chk_mem("R11 byte after load+stop", 8'hC8, 8'h12);
    endtask

    task automatic t_idle_ignore();
        do_byte(8'h99);
        do_stop();
        chk("R12 idle strobes no busy", busy, 0);
        @(negedge clk);
        chk("R12 still idle", busy, 0);
        chk_mem("R12 array unchanged", 8'hC9, 0);
    endtask

    task automatic t_flags();
        int n;
        do_load(8'hD0);
        do_byte(8'h01); do_byte(8'h02); do_byte(8'h03); do_byte(8'h04);
        do_stop();
        wait_idle(n);
        do_load(8'hE5);
        do_byte(8'h09);
        do_stop();
        wait_idle(n);
        chk_mem("R13 new byte", 8'hE5, 8'h09);
        chk_mem("R13 stale slot 0 not written", 8'hE0, 0);
        chk_mem("R13 stale slot 3 not written", 8'hE3, 0);
        chk_mem("R13 old page intact", 8'hD3, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap();
        t_rollover();
        t_busy_ignore();
        t_empty_stop();
        t_same_cycle();
        t_reload();
        t_idle_ignore();
        t_flags();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule